// File: doc/BRIEF.md
# Branch Tag Allocation and Squash Unit

This unit gives each predicted branch in flight a short tag taken from a small pool. Every instruction fetched is labelled with the tag that is current at that moment. Each new predicted branch takes the lowest-numbered free tag, and that tag becomes the current one. Tags are recycled, so their numeric values say nothing about age. A separate circular list records the order in which the live tags were handed out. A correctly resolved oldest branch hands its tag back from the head of that list.

When a branch mispredicts, the unit looks up the branch's tag in the ordered list. It then walks the tags that were allocated after it, broadcasting one tag per cycle on an invalidate bus. The list tail is pulled back so that the mispredicting branch's tag is current again. A small array of reservation-station entries is included. Each entry compares its stored tag with the broadcast and clears itself on a match. While the walk runs, or while every tag is in use, the unit raises a dispatch stall.

Top module: `brtag_ctrl`

## Requirements
- R1: After reset the current tag is 0, the only live tag is 0, and stall, busy and invalidate-valid are low. Every reservation-station entry is empty.
- R2: An accepted allocate request (alloc_req high, stall low, no mispredict in the same cycle) makes the lowest-numbered free tag current from the next cycle on.
- R3: A release names the oldest live tag, which is never the only live tag. That tag goes back to the free pool, so a later allocation can receive it again while higher-numbered tags are still live.
- R4: When all NUM_TAGS tags are live, dispatch_stall is high and an allocate request leaves the current tag unchanged. One cycle after a release, dispatch_stall is low again.
- R5: A mispredict carrying live tag T starts, on the next cycle, a broadcast of exactly the tags allocated after T. The broadcast sends them one per cycle, oldest first, with inv_valid high. recov_busy equals inv_valid.
- R6: A mispredict whose tag is the youngest live tag broadcasts nothing and leaves recov_busy low.
- R7: From the cycle after a mispredict on tag T, the current tag is T. While recov_busy is high, dispatch_stall is high and allocation requests have no effect. Once the broadcast ends, the freed tags can be allocated again, lowest number first.
- R8: If a mispredict and an allocate request arrive in the same cycle, the mispredict wins and no tag is taken from the pool.
- R9: A fill writes the current tag into the chosen reservation-station slot and marks it valid. A clear empties the slot. A valid entry whose tag equals a broadcast tag is empty from the next cycle; other entries are untouched.
- R10: The ordered list wraps around its storage correctly, for both allocation and the squash walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_req | input | 1 | A predicted branch asks for a new tag |
| rel_valid | input | 1 | The oldest branch resolved correctly |
| rel_tag | input | TAG_W | Tag being released |
| misp_valid | input | 1 | A branch mispredicted |
| misp_tag | input | TAG_W | Tag carried by the mispredicting branch |
| rs_fill | input | 1 | Write an instruction into a reservation-station slot |
| rs_fill_slot | input | SLOT_W | Slot to write |
| rs_clr | input | 1 | Empty a reservation-station slot |
| rs_clr_slot | input | SLOT_W | Slot to empty |
| cur_tag | output | TAG_W | Tag given to fetched instructions |
| dispatch_stall | output | 1 | New branches must wait |
| inv_valid | output | 1 | Invalidate broadcast active this cycle |
| inv_tag | output | TAG_W | Tag being invalidated |
| recov_busy | output | 1 | Squash walk in progress |
| rs_valid | output | NUM_RS | Valid bit of each reservation-station entry |

## Verification
The assertions assume the surrounding pipeline behaves. A release always names the oldest live tag and never the only one, and it never coincides with a mispredict. A mispredict names a live tag and never arrives while a walk is in progress. The directed bench keeps to these rules by tracking the tag order itself. It releases only the head tag it expects, and it waits until recov_busy is low before raising the next mispredict. Alloc requests are issued during a walk on purpose, because the unit must ignore them.

// File: rtl/brtag_pkg.sv
package brtag_pkg;

  typedef enum logic {
    WALK_IDLE = 1'b0,
    WALK_RUN  = 1'b1
  } walk_state_e;

  // Modular add on a ring of n slots; d must be below n.
  function automatic int unsigned ring_add(input int unsigned p,
                                           input int unsigned d,
                                           input int unsigned n);
    int unsigned s;
    s = p + d;
    if (s >= n) s = s - n;
    return s;
  endfunction

endpackage

// File: rtl/brtag_free_pool.sv
module brtag_free_pool #(
  parameter int NUM_TAGS = 8,
  parameter int TAG_W    = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                take,
  input  logic                give_a,
  input  logic [TAG_W-1:0]    give_a_tag,
  input  logic                give_b,
  input  logic [TAG_W-1:0]    give_b_tag,
  output logic [NUM_TAGS-1:0] free_mask,
  output logic [TAG_W-1:0]    pick_tag,
  output logic                none_free
);

  localparam logic [NUM_TAGS-1:0] INIT_MASK = ~(NUM_TAGS'(1));

  logic [NUM_TAGS-1:0] mask_q;
  logic [NUM_TAGS-1:0] mask_d;

  function automatic logic [TAG_W-1:0] lowest_free(input logic [NUM_TAGS-1:0] m);
    logic [TAG_W-1:0] r;
    r = '0;
    for (int i = NUM_TAGS - 1; i >= 0; i--) begin
      if (m[i]) r = TAG_W'(i);
    end
    return r;
  endfunction

  assign pick_tag  = lowest_free(mask_q);
  assign none_free = (mask_q == '0);
  assign free_mask = mask_q;

  always_comb begin
    mask_d = mask_q;
    if (take)   mask_d[pick_tag]   = 1'b0;
    if (give_a) mask_d[give_a_tag] = 1'b1;
    if (give_b) mask_d[give_b_tag] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) mask_q <= INIT_MASK;
    else        mask_q <= mask_d;
  end

endmodule

// File: rtl/brtag_order_list.sv
module brtag_order_list
  import brtag_pkg::*;
#(
  parameter int NUM_TAGS = 8,
  parameter int TAG_W    = 3,
  parameter int CNT_W    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [TAG_W-1:0] push_tag,
  input  logic             pop,
  input  logic             trunc,
  input  logic [TAG_W-1:0] find_tag,
  input  logic [TAG_W-1:0] rd_ptr,
  output logic             find_hit,
  output logic [TAG_W-1:0] find_ptr,
  output logic [CNT_W-1:0] find_idx,
  output logic [TAG_W-1:0] rd_tag,
  output logic [TAG_W-1:0] last_tag,
  output logic [TAG_W-1:0] head_tag,
  output logic [TAG_W-1:0] tail_ptr,
  output logic [CNT_W-1:0] count
);

  logic [TAG_W-1:0] slot_q [NUM_TAGS];
  logic [TAG_W-1:0] head_q;
  logic [TAG_W-1:0] tail_q;
  logic [CNT_W-1:0] cnt_q;

  logic [TAG_W-1:0]    ord_slot [NUM_TAGS];
  logic [NUM_TAGS-1:0] match;

  function automatic logic [TAG_W-1:0] ptr_next(input logic [TAG_W-1:0] p);
    return TAG_W'(ring_add(int'(p), 1, NUM_TAGS));
  endfunction

  function automatic logic [TAG_W-1:0] ptr_prev(input logic [TAG_W-1:0] p);
    return TAG_W'(ring_add(int'(p), NUM_TAGS - 1, NUM_TAGS));
  endfunction

  // Age-ordered view: position i counts from the oldest live entry.
  for (genvar i = 0; i < NUM_TAGS; i++) begin : g_ord
    assign ord_slot[i] = TAG_W'(ring_add(int'(head_q), i, NUM_TAGS));
    assign match[i]    = (CNT_W'(i) < cnt_q) && (slot_q[ord_slot[i]] == find_tag);
  end

  always_comb begin
    find_hit = 1'b0;
    find_ptr = '0;
    find_idx = '0;
    for (int i = 0; i < NUM_TAGS; i++) begin
      if (!find_hit && match[i]) begin
        find_hit = 1'b1;
        find_ptr = ord_slot[i];
        find_idx = CNT_W'(i);
      end
    end
  end

  assign rd_tag   = slot_q[rd_ptr];
  assign last_tag = slot_q[ptr_prev(tail_q)];
  assign head_tag = slot_q[head_q];
  assign tail_ptr = tail_q;
  assign count    = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_TAGS; i++) slot_q[i] <= '0;
      head_q <= '0;
      tail_q <= TAG_W'(1);
      cnt_q  <= CNT_W'(1);
    end else begin
      if (push) slot_q[tail_q] <= push_tag;
      if (pop)  head_q <= ptr_next(head_q);
      if (trunc) begin
        tail_q <= ptr_next(find_ptr);
        cnt_q  <= find_idx + CNT_W'(1);
      end else begin
        if (push) tail_q <= ptr_next(tail_q);
        cnt_q <= cnt_q + CNT_W'(push) - CNT_W'(pop);
      end
    end
  end

endmodule

// File: rtl/brtag_squash_walker.sv
module brtag_squash_walker
  import brtag_pkg::*;
#(
  parameter int NUM_TAGS = 8,
  parameter int TAG_W    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [TAG_W-1:0] start_ptr,
  input  logic [TAG_W-1:0] stop_ptr,
  input  logic [TAG_W-1:0] rd_tag,
  output logic [TAG_W-1:0] rd_ptr,
  output logic             busy,
  output logic             inv_valid,
  output logic [TAG_W-1:0] inv_tag
);

  walk_state_e      state_q;
  logic [TAG_W-1:0] walk_q;
  logic [TAG_W-1:0] stop_q;
  logic [TAG_W-1:0] walk_nxt;
  logic             walk_last;

  assign walk_nxt  = TAG_W'(ring_add(int'(walk_q), 1, NUM_TAGS));
  assign walk_last = (walk_nxt == stop_q);

  assign rd_ptr    = walk_q;
  assign busy      = (state_q == WALK_RUN);
  assign inv_valid = busy;
  assign inv_tag   = rd_tag;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= WALK_IDLE;
      walk_q  <= '0;
      stop_q  <= '0;
    end else begin
      case (state_q)
        WALK_IDLE: begin
          if (start) begin
            state_q <= WALK_RUN;
            walk_q  <= start_ptr;
            stop_q  <= stop_ptr;
          end
        end
        WALK_RUN: begin
          walk_q <= walk_nxt;
          if (walk_last) state_q <= WALK_IDLE;
        end
        default: state_q <= WALK_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/brtag_rs_array.sv
module brtag_rs_array #(
  parameter int NUM_RS = 8,
  parameter int TAG_W  = 3,
  parameter int SLOT_W = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    fill,
  input  logic [SLOT_W-1:0]       fill_slot,
  input  logic [TAG_W-1:0]        fill_tag,
  input  logic                    clr,
  input  logic [SLOT_W-1:0]       clr_slot,
  input  logic                    inv_valid,
  input  logic [TAG_W-1:0]        inv_tag,
  output logic [NUM_RS-1:0]       valid_vec,
  output logic [NUM_RS*TAG_W-1:0] tag_flat
);

  logic [NUM_RS-1:0] squash_hit;

  for (genvar i = 0; i < NUM_RS; i++) begin : g_ent
    logic             v_q;
    logic [TAG_W-1:0] t_q;
    logic             wr_here;
    logic             clr_here;

    assign wr_here       = fill && (fill_slot == SLOT_W'(i));
    assign clr_here      = clr && (clr_slot == SLOT_W'(i));
    assign squash_hit[i] = inv_valid && v_q && (t_q == inv_tag);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        t_q <= '0;
      end else if (wr_here) begin
        v_q <= 1'b1;
        t_q <= fill_tag;
      end else if (clr_here || squash_hit[i]) begin
        v_q <= 1'b0;
      end
    end

    assign valid_vec[i]                = v_q;
    assign tag_flat[i*TAG_W +: TAG_W] = t_q;
  end

endmodule

// File: rtl/brtag_ctrl.sv
module brtag_ctrl
  import brtag_pkg::*;
#(
  parameter int NUM_TAGS = 8,
  parameter int TAG_W    = $clog2(NUM_TAGS),
  parameter int NUM_RS   = 8,
  parameter int SLOT_W   = $clog2(NUM_RS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_req,
  input  logic              rel_valid,
  input  logic [TAG_W-1:0]  rel_tag,
  input  logic              misp_valid,
  input  logic [TAG_W-1:0]  misp_tag,
  input  logic              rs_fill,
  input  logic [SLOT_W-1:0] rs_fill_slot,
  input  logic              rs_clr,
  input  logic [SLOT_W-1:0] rs_clr_slot,
  output logic [TAG_W-1:0]  cur_tag,
  output logic              dispatch_stall,
  output logic              inv_valid,
  output logic [TAG_W-1:0]  inv_tag,
  output logic              recov_busy,
  output logic [NUM_RS-1:0] rs_valid
);

  localparam int CNT_W = $clog2(NUM_TAGS + 1);

  // Named internal events, also seen by the bound checker.
  logic [NUM_TAGS-1:0]     free_mask;
  logic [TAG_W-1:0]        pick_tag;
  logic                    none_free;
  logic                    find_hit;
  logic [TAG_W-1:0]        find_ptr;
  logic [CNT_W-1:0]        find_idx;
  logic [TAG_W-1:0]        rd_ptr;
  logic [TAG_W-1:0]        rd_tag;
  logic [TAG_W-1:0]        head_tag;
  logic [TAG_W-1:0]        tail_ptr;
  logic [CNT_W-1:0]        count;
  logic [CNT_W-1:0]        younger;
  logic                    walk_busy;
  logic                    alloc_grant;
  logic                    misp_go;
  logic                    walk_start;
  logic [TAG_W-1:0]        walk_first;
  logic [NUM_RS*TAG_W-1:0] rs_tag_flat;

  assign dispatch_stall = walk_busy | none_free;
  assign alloc_grant    = alloc_req & ~dispatch_stall & ~misp_valid;
  assign misp_go        = misp_valid & find_hit & ~walk_busy;
  assign younger        = count - find_idx - CNT_W'(1);
  assign walk_start     = misp_go && (younger != '0);
  assign walk_first     = TAG_W'(ring_add(int'(find_ptr), 1, NUM_TAGS));
  assign recov_busy     = walk_busy;

  brtag_free_pool #(
    .NUM_TAGS (NUM_TAGS),
    .TAG_W    (TAG_W)
  ) u_pool (
    .clk        (clk),
    .rst_n      (rst_n),
    .take       (alloc_grant),
    .give_a     (rel_valid),
    .give_a_tag (rel_tag),
    .give_b     (inv_valid),
    .give_b_tag (inv_tag),
    .free_mask  (free_mask),
    .pick_tag   (pick_tag),
    .none_free  (none_free)
  );

  brtag_order_list #(
    .NUM_TAGS (NUM_TAGS),
    .TAG_W    (TAG_W),
    .CNT_W    (CNT_W)
  ) u_list (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (alloc_grant),
    .push_tag (pick_tag),
    .pop      (rel_valid),
    .trunc    (misp_go),
    .find_tag (misp_tag),
    .rd_ptr   (rd_ptr),
    .find_hit (find_hit),
    .find_ptr (find_ptr),
    .find_idx (find_idx),
    .rd_tag   (rd_tag),
    .last_tag (cur_tag),
    .head_tag (head_tag),
    .tail_ptr (tail_ptr),
    .count    (count)
  );

  brtag_squash_walker #(
    .NUM_TAGS (NUM_TAGS),
    .TAG_W    (TAG_W)
  ) u_walk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (walk_start),
    .start_ptr (walk_first),
    .stop_ptr  (tail_ptr),
    .rd_tag    (rd_tag),
    .rd_ptr    (rd_ptr),
    .busy      (walk_busy),
    .inv_valid (inv_valid),
    .inv_tag   (inv_tag)
  );

  brtag_rs_array #(
    .NUM_RS (NUM_RS),
    .TAG_W  (TAG_W),
    .SLOT_W (SLOT_W)
  ) u_rs (
    .clk       (clk),
    .rst_n     (rst_n),
    .fill      (rs_fill),
    .fill_slot (rs_fill_slot),
    .fill_tag  (cur_tag),
    .clr       (rs_clr),
    .clr_slot  (rs_clr_slot),
    .inv_valid (inv_valid),
    .inv_tag   (inv_tag),
    .valid_vec (rs_valid),
    .tag_flat  (rs_tag_flat)
  );

endmodule

// File: rtl/brtag_ctrl_chk.sv
module brtag_ctrl_chk #(
  parameter int NUM_TAGS = 8,
  parameter int TAG_W    = 3,
  parameter int NUM_RS   = 8,
  parameter int SLOT_W   = 3,
  parameter int CNT_W    = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    rel_valid,
  input logic [TAG_W-1:0]        rel_tag,
  input logic                    misp_valid,
  input logic [TAG_W-1:0]        misp_tag,
  input logic                    rs_fill,
  input logic [SLOT_W-1:0]       rs_fill_slot,
  input logic [TAG_W-1:0]        cur_tag,
  input logic                    dispatch_stall,
  input logic                    inv_valid,
  input logic [TAG_W-1:0]        inv_tag,
  input logic                    recov_busy,
  input logic [NUM_RS-1:0]       rs_valid,
  input logic [NUM_TAGS-1:0]     free_mask,
  input logic [CNT_W-1:0]        count,
  input logic [TAG_W-1:0]        head_tag,
  input logic [NUM_RS*TAG_W-1:0] rs_tag_flat
);

  AST_CUR_TAG_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !free_mask[cur_tag]); // R2

  AST_POOL_LIST_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
    !recov_busy |-> (32'($countones(free_mask)) + 32'(count) == NUM_TAGS)); // R3

  AST_REL_IS_OLDEST: assert property (@(posedge clk) disable iff (!rst_n)
    rel_valid |-> (rel_tag == head_tag) && !free_mask[rel_tag] && (count > CNT_W'(1))); // R3

  AST_REL_NOT_WITH_MISP: assert property (@(posedge clk) disable iff (!rst_n)
    rel_valid |-> !misp_valid); // R3

  AST_FULL_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CNT_W'(NUM_TAGS)) |-> dispatch_stall); // R4

  AST_MISP_TAG_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    misp_valid |-> !free_mask[misp_tag] && !recov_busy); // R5

  AST_INV_TAG_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid |-> !free_mask[inv_tag] && (inv_tag != cur_tag)); // R5

  AST_BUSY_FREEZES_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    recov_busy |=> $stable(cur_tag)); // R7

  AST_BUSY_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    recov_busy |-> dispatch_stall); // R7

  for (genvar i = 0; i < NUM_RS; i++) begin : g_rs_chk
    AST_RS_SQUASH: assert property (@(posedge clk) disable iff (!rst_n)
      (inv_valid && rs_valid[i] && (rs_tag_flat[i*TAG_W +: TAG_W] == inv_tag)
       && !(rs_fill && (rs_fill_slot == SLOT_W'(i)))) |=> !rs_valid[i]); // R9
  end

endmodule

bind brtag_ctrl brtag_ctrl_chk #(
  .NUM_TAGS (NUM_TAGS),
  .TAG_W    (TAG_W),
  .NUM_RS   (NUM_RS),
  .SLOT_W   (SLOT_W),
  .CNT_W    (CNT_W)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .rel_valid      (rel_valid),
  .rel_tag        (rel_tag),
  .misp_valid     (misp_valid),
  .misp_tag       (misp_tag),
  .rs_fill        (rs_fill),
  .rs_fill_slot   (rs_fill_slot),
  .cur_tag        (cur_tag),
  .dispatch_stall (dispatch_stall),
  .inv_valid      (inv_valid),
  .inv_tag        (inv_tag),
  .recov_busy     (recov_busy),
  .rs_valid       (rs_valid),
  .free_mask      (free_mask),
  .count          (count),
  .head_tag       (head_tag),
  .rs_tag_flat    (rs_tag_flat)
);

// File: tb/brtag_ctrl_bench.sv
module brtag_ctrl_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       alloc_req = 1'b0;
  logic       rel_valid = 1'b0;
  logic [2:0] rel_tag = '0;
  logic       misp_valid = 1'b0;
  logic [2:0] misp_tag = '0;
  logic       rs_fill = 1'b0;
  logic [2:0] rs_fill_slot = '0;
  logic       rs_clr = 1'b0;
  logic [2:0] rs_clr_slot = '0;
  logic [2:0] cur_tag;
  logic       dispatch_stall;
  logic       inv_valid;
  logic [2:0] inv_tag;
  logic       recov_busy;
  logic [7:0] rs_valid;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  brtag_ctrl u_brtag_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .alloc_req      (alloc_req),
    .rel_valid      (rel_valid),
    .rel_tag        (rel_tag),
    .misp_valid     (misp_valid),
    .misp_tag       (misp_tag),
    .rs_fill        (rs_fill),
    .rs_fill_slot   (rs_fill_slot),
    .rs_clr         (rs_clr),
    .rs_clr_slot    (rs_clr_slot),
    .cur_tag        (cur_tag),
    .dispatch_stall (dispatch_stall),
    .inv_valid      (inv_valid),
    .inv_tag        (inv_tag),
    .recov_busy     (recov_busy),
    .rs_valid       (rs_valid)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_alloc();
    alloc_req = 1'b1; step(); alloc_req = 1'b0;
  endtask

  task automatic do_fill(input int slot);
    rs_fill = 1'b1; rs_fill_slot = 3'(slot); step(); rs_fill = 1'b0;
  endtask

  task automatic do_release(input int tag);
    rel_valid = 1'b1; rel_tag = 3'(tag); step(); rel_valid = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) step();
    rst_n = 1'b1;
    chk("R1 cur_tag", cur_tag, 0);
    chk("R1 stall", dispatch_stall, 0);
    chk("R1 busy", recov_busy, 0);
    chk("R1 inv_valid", inv_valid, 0);
    chk("R1 rs_valid", rs_valid, 0);
  endtask

  // Live tags become 0,1,2,3; slot3<-0, slot0<-1, slot1<-2, slot2<-3.
  task automatic t_alloc();
    do_fill(3);
    do_alloc(); chk("R2 first alloc", cur_tag, 1);
    do_fill(0);
    do_alloc(); chk("R2 second alloc", cur_tag, 2);
    do_fill(1);
    do_alloc(); chk("R2 third alloc", cur_tag, 3);
    do_fill(2);
    chk("R9 fills", rs_valid, 8'h0F);
  endtask

  task automatic t_misp_two();
    misp_valid = 1'b1; misp_tag = 3'd1; step(); misp_valid = 1'b0;
    chk("R7 cur after misp", cur_tag, 1);
    chk("R5 busy cycle1", recov_busy, 1);
    chk("R5 inv_valid cycle1", inv_valid, 1);
    chk("R5 inv_tag cycle1", inv_tag, 2);
    chk("R7 stall while busy", dispatch_stall, 1);
    alloc_req = 1'b1;
    step();
    chk("R5 inv_tag cycle2", inv_tag, 3);
    chk("R9 squash tag2", rs_valid, 8'h0D);
    step();
    alloc_req = 1'b0;
    chk("R5 busy ends", recov_busy, 0);
    chk("R5 inv ends", inv_valid, 0);
    chk("R9 squash tag3", rs_valid, 8'h09);
    chk("R7 alloc ignored while busy", cur_tag, 1);
    do_alloc(); chk("R7 reuse freed tag", cur_tag, 2);
  endtask

  task automatic t_misp_none();
    misp_valid = 1'b1; misp_tag = 3'd2; step(); misp_valid = 1'b0;
    chk("R6 no busy", recov_busy, 0);
    chk("R6 no inv", inv_valid, 0);
    chk("R6 cur tag", cur_tag, 2);
    step();
    chk("R6 still idle", recov_busy, 0);
  endtask

  // Live 0,1,2 -> release 0 -> allocate gets 0 again.
  task automatic t_release();
    do_release(0);
    do_alloc();
    chk("R3 recycled tag", cur_tag, 0);
  endtask

  // Order becomes 2,0,3,4,5,6,7,1 with storage wrapped.
  task automatic t_full();
    for (int t = 3; t <= 7; t++) begin
      do_alloc();
      chk("R2 fill pool", cur_tag, t);
    end
    chk("R4 stall when full", dispatch_stall, 1);
    do_alloc();
    chk("R4 alloc ignored when full", cur_tag, 7);
    do_release(1);
    chk("R4 stall drops", dispatch_stall, 0);
    do_alloc();
    chk("R10 alloc after wrap", cur_tag, 1);
    chk("R4 full again", dispatch_stall, 1);
  endtask

  task automatic t_wrap_misp();
    misp_valid = 1'b1; misp_tag = 3'd5; step(); misp_valid = 1'b0;
    chk("R10 cur after misp", cur_tag, 5);
    chk("R10 inv 1st", inv_tag, 6);
    step();
    chk("R10 inv 2nd", inv_tag, 7);
    chk("R5 busy 2nd", recov_busy, 1);
    step();
    chk("R10 inv 3rd", inv_tag, 1);
    chk("R5 valid 3rd", inv_valid, 1);
    step();
    chk("R5 done after three", recov_busy, 0);
    chk("R9 stale tag1 squashed", rs_valid, 8'h08);
  endtask

  task automatic t_misp_alloc();
    misp_valid = 1'b1; misp_tag = 3'd3; alloc_req = 1'b1;
    step();
    misp_valid = 1'b0; alloc_req = 1'b0;
    chk("R8 misp wins", cur_tag, 3);
    chk("R8 inv 1st", inv_tag, 4);
    step();
    chk("R8 inv 2nd", inv_tag, 5);
    step();
    chk("R8 busy ends", recov_busy, 0);
    do_alloc();
    chk("R8 no tag lost", cur_tag, 1);
  endtask

  task automatic t_rs_clear();
    do_fill(5);
    chk("R9 fill slot5", rs_valid, 8'h28);
    rs_clr = 1'b1; rs_clr_slot = 3'd3; step(); rs_clr = 1'b0;
    chk("R9 clear slot3", rs_valid, 8'h20);
  endtask

  initial begin
    t_reset();
    t_alloc();
    t_misp_two();
    t_misp_none();
    t_release();
    t_full();
    t_wrap_misp();
    t_misp_alloc();
    t_rs_clear();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule